// File: doc/BRIEF.md
# GPIO Controller with Per-Line Interrupt Detection

This block controls sixteen general-purpose I/O lines behind a small 32-bit register bus. Software sets an output value and a direction for each line, reads the pin levels, and picks for every line one of five ways of raising an interrupt: while the pin is high, while it is low, on a rising edge, on a falling edge, or on any change. A detected condition sets a sticky status bit that software clears by writing a one to it. The status bits of the low thirteen lines drive thirteen active-high interrupt outputs toward the chip's interrupt controller.

Every pin passes through a two-flop synchroniser. Input readback and the detectors both see the synchronised level, and edges are found by comparing it with its value one cycle earlier. Bus writes take effect on the clock edge where `bus_we` is high, and reads return the addressed register in the same cycle. Bits 1:0 of the byte address are ignored.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After a synchronous reset, the direction register reads 0xFFFF (every line an input, `pin_oe` all zero), and output data, status and both style registers read zero.
- R2: Output data is held at offset 0x00 and drives `pin_out`. Direction is held at offset 0x04, where a 1 makes the line an input. `pin_oe[i]` is high exactly when direction bit i is 0.
- R3: Offset 0x08 reads the pin levels after a two-flop synchroniser. A pin change becomes visible after the second rising clock edge, and writes to 0x08 have no effect.
- R4: Line i has a 3-bit style field at bit 3×(i mod 8): at offset 0x10 for lines 0–7 and at offset 0x14 for lines 8–15. Bits 31:24 of both style registers read zero.
- R5: Style code 2 sets status on a rising edge, 3 on a falling edge and 4 on either edge. An edge is a change of the synchronised level since the previous cycle. Status is set on the third rising clock edge after the pin changes, and a steady level sets nothing more.
- R6: Style code 0 sets status on every cycle the synchronised level is high, and code 1 on every cycle it is low. A clear has no lasting effect while the level persists.
- R7: Style codes 5, 6 and 7 never set status.
- R8: Status sits at offset 0x0C, one bit per line. Writing 1 to a bit clears it, writing 0 leaves it unchanged, and a set bit stays set until it is cleared.
- R9: When a detection and a clear of the same status bit fall in the same cycle, the bit ends up set.
- R10: `irq_out[i]` follows status bit i for lines 0–12. Lines 13–15 record status but drive no interrupt output.
- R11: Offsets 0x18 and 0x1C read zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 5 | Byte address of the register |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| pin_in | input | 16 | Asynchronous pin levels |
| pin_out | output | 16 | Output value for each line |
| pin_oe | output | 16 | Output driver enable, high for lines set as outputs |
| irq_out | output | 13 | Active-high interrupt for lines 0–12 |

## Verification
The hardest case to reach is a write-one-to-clear that lands on the same clock edge as a fresh edge detection on the same line. A pin edge needs three clock edges to reach status, so the bench raises the pin, waits exactly two edges, and then issues the clear so that it commits on the detecting edge. The level styles are driven the same way to show that a clear cannot hold while the level persists. The unused style codes are toggled in both directions to show that they never set status.

// File: rtl/gpio_irq_pkg.sv
// Package for the GPIO interrupt controller.
// Holds the register word indices (byte address bits 4:2), the bus widths
// and the detection-style codes. Assumes eight lines per style register.
package gpio_irq_pkg;
    localparam int DATA_W        = 32;
    localparam int WORD_W        = 3;
    localparam int ADDR_W        = WORD_W + 2;
    localparam int STY_W         = 3;
    localparam int LINES_PER_STY = 8;

    localparam logic [WORD_W-1:0] WORD_OUT  = 3'd0;
    localparam logic [WORD_W-1:0] WORD_DIR  = 3'd1;
    localparam logic [WORD_W-1:0] WORD_IN   = 3'd2;
    localparam logic [WORD_W-1:0] WORD_STAT = 3'd3;
    localparam logic [WORD_W-1:0] WORD_STY0 = 3'd4;
    localparam logic [WORD_W-1:0] WORD_STY1 = 3'd5;

    typedef enum logic [STY_W-1:0] {
        STY_LVL_HI = 3'd0,
        STY_LVL_LO = 3'd1,
        STY_RISE   = 3'd2,
        STY_FALL   = 3'd3,
        STY_ANY    = 3'd4
    } style_e;

    // Word index of the style register that holds a given line
    function automatic logic [WORD_W-1:0] style_word(input int line);
        return WORD_STY0 + WORD_W'(line / LINES_PER_STY);
    endfunction
endpackage

// File: rtl/gpio_sync.sv
// Two-flop synchroniser for a bus of independent asynchronous pins.
// Assumes each bit is a separate signal, so bits may settle in different cycles.
module gpio_sync #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    logic [WIDTH-1:0] meta_q;
    logic [WIDTH-1:0] sync_q;

    // Two capture stages, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
        end
    end

    assign sync_o = sync_q;
endmodule

// File: rtl/gpio_detect.sv
// Per-line interrupt condition detector.
// For each line, compares the synchronised level with last cycle's level
// and raises set_o for one cycle per edge, or on every cycle of a level,
// depending on the line's style code. Codes with no style never raise it.
module gpio_detect #(
    parameter int LINES = 16
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic [LINES-1:0]                          lvl_i,
    input  logic [LINES-1:0][gpio_irq_pkg::STY_W-1:0] style_i,
    output logic [LINES-1:0]                          set_o
);
    import gpio_irq_pkg::*;

    logic [LINES-1:0] prev_q;

    // Level from one cycle back, for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= lvl_i;
    end

    for (genvar g = 0; g < LINES; g++) begin : g_line
        // Decode this line's style into its set condition
        always_comb begin
            case (style_i[g])
                STY_LVL_HI: set_o[g] = lvl_i[g];
                STY_LVL_LO: set_o[g] = ~lvl_i[g];
                STY_RISE:   set_o[g] = lvl_i[g] & ~prev_q[g];
                STY_FALL:   set_o[g] = ~lvl_i[g] & prev_q[g];
                STY_ANY:    set_o[g] = lvl_i[g] ^ prev_q[g];
                default:    set_o[g] = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/gpio_irq_ctrl.sv
// GPIO controller top: register file, synchroniser, detectors, status.
// Assumes one-cycle write strobes and word-aligned addresses. Reads are
// combinational, and offsets 0x18/0x1C are reserved and read zero.
// Status set takes priority over a same-cycle write-one-to-clear.
module gpio_irq_ctrl #(
    parameter int NLINES = 16,
    parameter int NIRQ   = 13
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [gpio_irq_pkg::ADDR_W-1:0] bus_addr,
    input  logic                            bus_we,
    input  logic [gpio_irq_pkg::DATA_W-1:0] bus_wdata,
    output logic [gpio_irq_pkg::DATA_W-1:0] bus_rdata,
    input  logic [NLINES-1:0]               pin_in,
    output logic [NLINES-1:0]               pin_out,
    output logic [NLINES-1:0]               pin_oe,
    output logic [NIRQ-1:0]                 irq_out
);
    import gpio_irq_pkg::*;

    localparam int SPR = LINES_PER_STY;

    logic [WORD_W-1:0]             word;
    logic [NLINES-1:0]             out_q;
    logic [NLINES-1:0]             dir_q;
    logic [NLINES-1:0]             status_q;
    logic [NLINES-1:0][STY_W-1:0]  style_q;
    logic [NLINES-1:0]             lvl_sync;
    logic [NLINES-1:0]             set_vec;
    logic [NLINES-1:0]             clr_mask;
    logic                          unused_bits;

    assign word        = bus_addr[ADDR_W-1:2];
    assign unused_bits = &{bus_addr[1:0], bus_wdata[DATA_W-1:SPR*STY_W]};

    gpio_sync #(.WIDTH(NLINES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (pin_in),
        .sync_o  (lvl_sync)
    );

    gpio_detect #(.LINES(NLINES)) u_detect (
        .clk     (clk),
        .rst_n   (rst_n),
        .lvl_i   (lvl_sync),
        .style_i (style_q),
        .set_o   (set_vec)
    );

    // Output-data and direction registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
            dir_q <= '1;
        end else if (bus_we) begin
            if (word == WORD_OUT) out_q <= bus_wdata[NLINES-1:0];
            if (word == WORD_DIR) dir_q <= bus_wdata[NLINES-1:0];
        end
    end

    // Style fields, each written from its own register word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            style_q <= '0;
        end else begin
            for (int i = 0; i < NLINES; i++) begin
                if (bus_we && word == style_word(i))
                    style_q[i] <= bus_wdata[(i % SPR) * STY_W +: STY_W];
            end
        end
    end

    // Bits that a status write asks to clear
    always_comb begin
        clr_mask = '0;
        if (bus_we && word == WORD_STAT) clr_mask = bus_wdata[NLINES-1:0];
    end

    // Sticky status: clear first, then OR in new detections
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= '0;
        else        status_q <= (status_q & ~clr_mask) | set_vec;
    end

    // Read multiplexer for the addressed word
    always_comb begin
        bus_rdata = '0;
        case (word)
            WORD_OUT:  bus_rdata[NLINES-1:0] = out_q;
            WORD_DIR:  bus_rdata[NLINES-1:0] = dir_q;
            WORD_IN:   bus_rdata[NLINES-1:0] = lvl_sync;
            WORD_STAT: bus_rdata[NLINES-1:0] = status_q;
            default: begin
                for (int i = 0; i < NLINES; i++) begin
                    if (word == style_word(i))
                        bus_rdata[(i % SPR) * STY_W +: STY_W] = style_q[i];
                end
            end
        endcase
    end

    assign pin_out = out_q;
    assign pin_oe  = ~dir_q;
    assign irq_out = status_q[NIRQ-1:0];
endmodule

// File: rtl/gpio_irq_checker.sv
// Assertion checker for gpio_irq_ctrl, attached by bind.
// Observes the bus, the pin enables and the status/detector signals.
module gpio_irq_checker #(
    parameter int NLINES = 16
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic [gpio_irq_pkg::ADDR_W-1:0] bus_addr,
    input logic                            bus_we,
    input logic [gpio_irq_pkg::DATA_W-1:0] bus_wdata,
    input logic [gpio_irq_pkg::DATA_W-1:0] bus_rdata,
    input logic [NLINES-1:0]               pin_oe,
    input logic [NLINES-1:0]               status_q,
    input logic [NLINES-1:0]               set_vec
);
    import gpio_irq_pkg::*;

    logic [WORD_W-1:0] word;
    logic              stat_wr;
    assign word    = bus_addr[ADDR_W-1:2];
    assign stat_wr = bus_we && (word == WORD_STAT);

    // A detection always reaches status, even against a clear
    assert_set_lands_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_vec) |=> ((status_q & $past(set_vec)) == $past(set_vec)));

    // Without a status write, no set bit drops
    assert_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> ((status_q & $past(status_q)) == $past(status_q)));

    // A status bit only rises after its detector fired
    assert_no_spurious_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (|(~status_q)) |=> ((status_q & ~$past(status_q) & ~$past(set_vec)) == '0));

    // Style registers never return data in bits 31:24
    assert_style_top_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (word == WORD_STY0 || word == WORD_STY1) |-> (bus_rdata[31:24] == 8'h00));

    // Direction write sets the driver enables to its inverse
    assert_dir_to_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && word == WORD_DIR) |=> (pin_oe == ~$past(bus_wdata[NLINES-1:0])));
endmodule

bind gpio_irq_ctrl gpio_irq_checker #(.NLINES(NLINES)) u_check (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_oe    (pin_oe),
    .status_q  (status_q),
    .set_vec   (set_vec)
);

// File: tb/test_gpio_irq_ctrl.sv
// Self-checking bench for gpio_irq_ctrl: a register vector table, then
// directed tests for synchroniser latency, each style, clears and reset.
module test_gpio_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [15:0] pin_in = '0;
    logic [15:0] pin_out;
    logic [15:0] pin_oe;
    logic [12:0] irq_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_irq_ctrl i_gpio_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
    );

    // Register vectors: write flag, byte address, data, expected read.
    // Covers R2 (0x00/0x04), R4 (style packing, 31:24 zero),
    // R11 (0x18/0x1C reserved) and R3 (0x08 ignores writes).
    localparam int NV = 14;
    localparam logic        TW [NV] = '{1, 0, 1, 0, 1, 0, 1, 0, 1, 0, 1, 0, 1, 0};
    localparam logic [4:0]  TA [NV] = '{5'h00, 5'h00, 5'h04, 5'h04, 5'h10, 5'h10,
                                        5'h14, 5'h14, 5'h18, 5'h18, 5'h1C, 5'h1C,
                                        5'h08, 5'h08};
    localparam logic [31:0] TD [NV] = '{32'hA5C3, 0, 32'h00FF, 0, 32'hFFFFFFFF, 0,
                                        32'h12345678, 0, 32'hFFFFFFFF, 0, 32'h1, 0,
                                        32'hFFFF, 0};
    localparam logic [31:0] TE [NV] = '{0, 32'hA5C3, 0, 32'h00FF, 0, 32'h00FFFFFF,
                                        0, 32'h00345678, 0, 32'h0, 0, 32'h0,
                                        0, 32'h0};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called at a negedge; commits on the next posedge, returns at next negedge
    task automatic bus_write(input logic [4:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    // Combinational read, zero cycles
    task automatic bus_read(input logic [4:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic read_chk(input string req, input logic [4:0] a,
                            input logic [31:0] mask, input logic [31:0] exp);
        logic [31:0] d;
        bus_read(a, d);
        chk(req, d & mask, exp);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst_n = 1'b1;

        // R1: reset state
        read_chk("R1 out", 5'h00, 32'hFFFFFFFF, 32'h0);
        read_chk("R1 dir", 5'h04, 32'hFFFFFFFF, 32'hFFFF);
        read_chk("R1 status", 5'h0C, 32'hFFFFFFFF, 32'h0);
        read_chk("R1 style0", 5'h10, 32'hFFFFFFFF, 32'h0);
        read_chk("R1 style1", 5'h14, 32'hFFFFFFFF, 32'h0);
        chk("R1 pin_oe", {16'h0, pin_oe}, 32'h0);
        chk("R1 irq_out", {19'h0, irq_out}, 32'h0);

        // Vector table walk
        for (int k = 0; k < NV; k++) begin
            if (TW[k]) bus_write(TA[k], TD[k]);
            else       read_chk("R2/R3/R4/R11 table", TA[k], 32'hFFFFFFFF, TE[k]);
        end
        chk("R2 pin_out", {16'h0, pin_out}, 32'hA5C3);
        chk("R2 pin_oe", {16'h0, pin_oe}, 32'hFF00);

        // Tidy: styles zero, all inputs, clear status
        bus_write(5'h10, 32'h0);
        bus_write(5'h14, 32'h0);
        bus_write(5'h04, 32'hFFFF);
        bus_write(5'h0C, 32'hFFFF);
        read_chk("R8 clear all", 5'h0C, 32'hFFFFFFFF, 32'h0);

        // R3 latency and R6 level high, R10 outputs for lines 0 and 15
        pin_in = 16'h8001;
        wait_n(1);
        read_chk("R3 one edge", 5'h08, 32'hFFFFFFFF, 32'h0);
        wait_n(1);
        read_chk("R3 two edges", 5'h08, 32'hFFFFFFFF, 32'h8001);
        wait_n(1);
        read_chk("R6 level high set", 5'h0C, 32'hFFFFFFFF, 32'h8001);
        chk("R10 irq_out", {19'h0, irq_out}, 32'h0001);
        bus_write(5'h0C, 32'hFFFF);
        read_chk("R6 clear does not hold", 5'h0C, 32'hFFFFFFFF, 32'h8001);
        pin_in = 16'h0000;
        wait_n(3);
        bus_write(5'h0C, 32'hFFFF);
        read_chk("R6 clear after level gone", 5'h0C, 32'hFFFFFFFF, 32'h0);
        chk("R10 irq_out low", {19'h0, irq_out}, 32'h0);

        // R6 level low on line 1 (style code 1 at bits 5:3)
        bus_write(5'h10, 32'h8);
        wait_n(1);
        read_chk("R6 level low set", 5'h0C, 32'h2, 32'h2);
        pin_in = 16'h0002;
        wait_n(3);
        bus_write(5'h0C, 32'h2);
        read_chk("R6 level low cleared", 5'h0C, 32'h2, 32'h0);

        // Styles: line1=1, line2=2 rise, line3=3 fall, line4=4 any, line5=5 unused
        bus_write(5'h10, 32'h0002C688);
        read_chk("R4 style readback", 5'h10, 32'hFFFFFFFF, 32'h0002C688);

        // R5 rising on line 2
        pin_in = 16'h0006;
        wait_n(2);
        read_chk("R5 rise not yet", 5'h0C, 32'h4, 32'h0);
        wait_n(1);
        read_chk("R5 rise set", 5'h0C, 32'h4, 32'h4);
        chk("R10 irq line2", {31'h0, irq_out[2]}, 32'h1);
        bus_write(5'h0C, 32'h0);
        read_chk("R8 write zero keeps", 5'h0C, 32'h4, 32'h4);
        bus_write(5'h0C, 32'h4);
        wait_n(2);
        read_chk("R5 steady high no reset", 5'h0C, 32'h4, 32'h0);

        // R5 falling on line 3
        pin_in = 16'h000E;
        wait_n(3);
        read_chk("R5 fall ignores rise", 5'h0C, 32'h8, 32'h0);
        pin_in = 16'h0006;
        wait_n(3);
        read_chk("R5 fall set", 5'h0C, 32'h8, 32'h8);
        bus_write(5'h0C, 32'h8);
        read_chk("R8 fall cleared", 5'h0C, 32'h8, 32'h0);

        // R5 either edge on line 4
        pin_in = 16'h0016;
        wait_n(3);
        read_chk("R5 any rise", 5'h0C, 32'h10, 32'h10);
        bus_write(5'h0C, 32'h10);
        read_chk("R5 any cleared", 5'h0C, 32'h10, 32'h0);
        pin_in = 16'h0006;
        wait_n(3);
        read_chk("R5 any fall", 5'h0C, 32'h10, 32'h10);
        bus_write(5'h0C, 32'h10);

        // R7 unused code on line 5
        pin_in = 16'h0026;
        wait_n(3);
        read_chk("R7 code5 rise", 5'h0C, 32'h20, 32'h0);
        pin_in = 16'h0006;
        wait_n(3);
        read_chk("R7 code5 fall", 5'h0C, 32'h20, 32'h0);

        // R9 same-cycle set and clear on line 2
        pin_in = 16'h0002;
        wait_n(3);
        bus_write(5'h0C, 32'h4);
        pin_in = 16'h0006;
        wait_n(2);
        bus_write(5'h0C, 32'h4);
        read_chk("R9 set wins", 5'h0C, 32'h4, 32'h4);
        bus_write(5'h0C, 32'h4);
        read_chk("R9 later clear", 5'h0C, 32'h4, 32'h0);

        // R1 reset mid-run
        bus_write(5'h00, 32'h1234);
        bus_write(5'h04, 32'h0);
        rst_n = 1'b0;
        wait_n(2);
        rst_n = 1'b1;
        read_chk("R1 rerun dir", 5'h04, 32'hFFFFFFFF, 32'hFFFF);
        read_chk("R1 rerun style", 5'h10, 32'hFFFFFFFF, 32'h0);
        read_chk("R1 rerun status", 5'h0C, 32'hFFFFFFFF, 32'h0);
        chk("R1 rerun pin_out", {16'h0, pin_out}, 32'h0);
        chk("R1 rerun pin_oe", {16'h0, pin_oe}, 32'h0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule